// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block sits between an 8-bit timer's compare-match logic and one general-purpose I/O pin. It keeps a single compare output flip-flop. On each timer event the flip-flop is toggled, cleared, set or left alone. The action depends on a two-bit output action field and on the timer's waveform mode: normal, CTC (clear timer on compare), fast PWM or phase-correct PWM. The same field also decides where the pin's output value comes from. At 00 the pin takes its value from the port data bit. At any other value the pin takes it from the compare flip-flop.

The pin's direction is never taken over by this block. The output enable always follows the port direction bit, so the compare value only appears on the pin once that bit selects output. In the non-PWM modes a force strobe applies the match action at once. This lets software load the flip-flop with a known level before the pin is switched to output.

The timer sets the waveform mode and the action field. Both are captured into a configuration register on every clock and act on the events of the following cycle. The counter provides the event strobes: a compare match, a counting-down flag, and a BOTTOM strobe. The pin value and the output enable are registered outputs.

Top module: `oc_pin_unit`

## Requirements
- R1: A synchronous active-high reset drives both pin outputs low, clears the compare flip-flop and clears the captured configuration. After reset the pin value comes from the port data bit until a nonzero action field has been captured.
- R2: While the captured action field is 00, the pin value equals the port data bit of the previous cycle, and no strobe changes the compare flip-flop.
- R3: The output enable equals the port direction bit of the previous cycle in every mode and for every action field.
- R4: While the captured action field is nonzero, the pin value equals the compare flip-flop after that cycle's update, in every waveform mode.
- R5: The waveform mode (00 normal, 01 CTC, 10 fast PWM, 11 phase-correct PWM) and the action field are sampled on every clock edge. They govern the events and the pin source of the next cycle.
- R6: In normal and CTC modes a match applies the action field: 01 toggles the flip-flop, 10 clears it, 11 sets it.
- R7: In fast PWM mode, field 10 clears the flip-flop on a match and sets it on BOTTOM, and field 11 does the opposite. When match and BOTTOM arrive in the same cycle, the BOTTOM action wins. Field 01 leaves the flip-flop unchanged.
- R8: In phase-correct PWM mode, field 10 clears the flip-flop on a match while counting up (count-down flag 0) and sets it on a match while counting down. Field 11 does the opposite, and field 01 leaves the flip-flop unchanged.
- R9: In normal and CTC modes the force strobe applies the same action as a match. A force and a match in the same cycle apply that action only once.
- R10: In both PWM modes the force strobe has no effect on the flip-flop.
- R11: The flip-flop can be preset with force while the port direction bit is 0, with the output enable low. When the direction bit is then set, the preset level appears on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wave_mode_i | input | 2 | Waveform mode: 00 normal, 01 CTC, 10 fast PWM, 11 phase-correct PWM |
| cmp_mode_i | input | 2 | Output action field |
| match_i | input | 1 | Compare-match strobe from the counter |
| count_down_i | input | 1 | Counter direction, 1 while counting down |
| bottom_i | input | 1 | Counter-at-BOTTOM strobe |
| force_i | input | 1 | Force-compare strobe |
| port_data_i | input | 1 | Port data register bit |
| port_dir_i | input | 1 | Port direction register bit, 1 = output |
| pin_out_o | output | 1 | Registered pin output value |
| pin_oe_o | output | 1 | Registered pin output enable |

## Verification
Some properties are checked by assertions on every cycle:
- The output enable tracks the direction bit.
- The pin source follows the captured action field.
- The flip-flop stays unchanged while the field is 00, under a reserved PWM field, and under a lone force in PWM modes.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- The exact set, clear and toggle outcomes in each waveform mode.
- The priority of BOTTOM over match.
- The single action for a coincident force and match.
- The preset-then-enable sequence.
- The one-cycle lag of configuration changes.

// File: rtl/oc_pin_pkg.sv
package oc_pin_pkg;

  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    WG_NORMAL = 2'b00,
    WG_CTC    = 2'b01,
    WG_FAST   = 2'b10,
    WG_PHASE  = 2'b11
  } wave_e;

  typedef enum logic [MODE_W-1:0] {
    CO_OFF    = 2'b00,
    CO_TOGGLE = 2'b01,
    CO_CLEAR  = 2'b10,
    CO_SET    = 2'b11
  } com_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_TOGGLE,
    ACT_CLEAR,
    ACT_SET
  } act_e;

  typedef struct packed {
    wave_e wave;
    com_e  com;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{wave: WG_NORMAL, com: CO_OFF};

  function automatic logic is_pwm(input wave_e w);
    return (w == WG_FAST) || (w == WG_PHASE);
  endfunction

endpackage

// File: rtl/oc_cfg_reg.sv
module oc_cfg_reg
  import oc_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] wave_i,
  input  logic [MODE_W-1:0] com_i,
  output cfg_t              cfg_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o <= CFG_RESET;
    end else begin
      cfg_o.wave <= wave_e'(wave_i);
      cfg_o.com  <= com_e'(com_i);
    end
  end

endmodule

// File: rtl/oc_action.sv
module oc_action
  import oc_pin_pkg::*;
(
  input  cfg_t cfg_i,
  input  logic match_i,
  input  logic down_i,
  input  logic bottom_i,
  input  logic force_i,
  output act_e act_o
);

  function automatic act_e direct_act(input com_e c);
    case (c)
      CO_TOGGLE: return ACT_TOGGLE;
      CO_CLEAR:  return ACT_CLEAR;
      CO_SET:    return ACT_SET;
      default:   return ACT_NONE;
    endcase
  endfunction

  // Inverting field (11) flips set/clear relative to non-inverting (10).
  logic inverting;
  logic pwm_active;

  assign inverting  = (cfg_i.com == CO_SET);
  assign pwm_active = (cfg_i.com == CO_CLEAR) || (cfg_i.com == CO_SET);

  always_comb begin
    act_o = ACT_NONE;
    case (cfg_i.wave)
      WG_NORMAL, WG_CTC: begin
        if (match_i || force_i) begin
          act_o = direct_act(cfg_i.com);
        end
      end
      WG_FAST: begin
        if (pwm_active) begin
          if (bottom_i) begin
            act_o = inverting ? ACT_CLEAR : ACT_SET;
          end else if (match_i) begin
            act_o = inverting ? ACT_SET : ACT_CLEAR;
          end
        end
      end
      WG_PHASE: begin
        if (pwm_active && match_i) begin
          if (down_i ^ inverting) begin
            act_o = ACT_SET;
          end else begin
            act_o = ACT_CLEAR;
          end
        end
      end
      default: act_o = ACT_NONE;
    endcase
  end

endmodule

// File: rtl/oc_flop.sv
module oc_flop
  import oc_pin_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  act_e act_i,
  output logic oc_d_o,
  output logic oc_q_o
);

  always_comb begin
    case (act_i)
      ACT_TOGGLE: oc_d_o = ~oc_q_o;
      ACT_CLEAR:  oc_d_o = 1'b0;
      ACT_SET:    oc_d_o = 1'b1;
      default:    oc_d_o = oc_q_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_q_o <= 1'b0;
    end else begin
      oc_q_o <= oc_d_o;
    end
  end

endmodule

// File: rtl/oc_pin_drive.sv
module oc_pin_drive
  import oc_pin_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  com_e com_i,
  input  logic oc_d_i,
  input  logic port_data_i,
  input  logic port_dir_i,
  output logic pin_out_o,
  output logic pin_oe_o
);

  logic take_over;

  assign take_over = (com_i != CO_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out_o <= 1'b0;
      pin_oe_o  <= 1'b0;
    end else begin
      pin_out_o <= take_over ? oc_d_i : port_data_i;
      pin_oe_o  <= port_dir_i;
    end
  end

endmodule

// File: rtl/oc_pin_unit.sv
module oc_pin_unit
  import oc_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] wave_mode_i,
  input  logic [MODE_W-1:0] cmp_mode_i,
  input  logic              match_i,
  input  logic              count_down_i,
  input  logic              bottom_i,
  input  logic              force_i,
  input  logic              port_data_i,
  input  logic              port_dir_i,
  output logic              pin_out_o,
  output logic              pin_oe_o
);

  cfg_t              cfg_q;
  act_e              act;
  logic              oc_d;
  logic              oc_q;
  logic [MODE_W-1:0] com_q_bits;
  logic [MODE_W-1:0] wave_q_bits;

  assign com_q_bits  = cfg_q.com;
  assign wave_q_bits = cfg_q.wave;

  oc_cfg_reg i_cfg (
    .clk    (clk),
    .rst    (rst),
    .wave_i (wave_mode_i),
    .com_i  (cmp_mode_i),
    .cfg_o  (cfg_q)
  );

  oc_action i_act (
    .cfg_i    (cfg_q),
    .match_i  (match_i),
    .down_i   (count_down_i),
    .bottom_i (bottom_i),
    .force_i  (force_i),
    .act_o    (act)
  );

  oc_flop i_oc (
    .clk    (clk),
    .rst    (rst),
    .act_i  (act),
    .oc_d_o (oc_d),
    .oc_q_o (oc_q)
  );

  oc_pin_drive i_drv (
    .clk         (clk),
    .rst         (rst),
    .com_i       (cfg_q.com),
    .oc_d_i      (oc_d),
    .port_data_i (port_data_i),
    .port_dir_i  (port_dir_i),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o)
  );

endmodule

// File: rtl/oc_pin_unit_chk.sv
module oc_pin_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] com_q,
  input logic [1:0] wave_q,
  input logic       oc_q,
  input logic       match_i,
  input logic       bottom_i,
  input logic       force_i,
  input logic       port_data_i,
  input logic       port_dir_i,
  input logic       pin_out_o,
  input logic       pin_oe_o
);

  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pin_oe_o == $past(port_dir_i)); // R3

  AST_PORT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (com_q == 2'b00) |=> pin_out_o == $past(port_data_i)); // R2

  AST_OC_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (com_q != 2'b00) |=> pin_out_o == oc_q); // R4

  AST_OFF_HOLDS_OC: assert property (@(posedge clk) disable iff (rst)
    (com_q == 2'b00) |=> $stable(oc_q)); // R2

  AST_PWM_FORCE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wave_q[1] && force_i && !match_i && !bottom_i) |=> $stable(oc_q)); // R10

  AST_PWM_RESERVED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wave_q[1] && com_q == 2'b01) |=> $stable(oc_q)); // R7 R8

endmodule

bind oc_pin_unit oc_pin_unit_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .com_q       (com_q_bits),
  .wave_q      (wave_q_bits),
  .oc_q        (oc_q),
  .match_i     (match_i),
  .bottom_i    (bottom_i),
  .force_i     (force_i),
  .port_data_i (port_data_i),
  .port_dir_i  (port_dir_i),
  .pin_out_o   (pin_out_o),
  .pin_oe_o    (pin_oe_o)
);

// File: tb/test_oc_pin_unit.sv
`timescale 1ns/1ps
module test_oc_pin_unit;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] wave_mode_i, cmp_mode_i;
  logic       match_i, count_down_i, bottom_i, force_i;
  logic       port_data_i, port_dir_i;
  logic       pin_out_o, pin_oe_o;

  always #4 clk = ~clk;

  oc_pin_unit i_oc_pin_unit (
    .clk          (clk),
    .rst          (rst),
    .wave_mode_i  (wave_mode_i),
    .cmp_mode_i   (cmp_mode_i),
    .match_i      (match_i),
    .count_down_i (count_down_i),
    .bottom_i     (bottom_i),
    .force_i      (force_i),
    .port_data_i  (port_data_i),
    .port_dir_i   (port_dir_i),
    .pin_out_o    (pin_out_o),
    .pin_oe_o     (pin_oe_o)
  );

  typedef struct {
    logic  pin;
    logic  oe;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference model state
  logic [1:0] m_wave = 2'b00, m_com = 2'b00;
  logic       m_oc = 1'b0;

  // held stimulus
  logic [1:0] b_wave = 2'b00, b_com = 2'b00;
  logic       b_pd = 1'b0, b_dir = 1'b0, b_rst = 1'b1;

  function automatic logic model_next(input logic [1:0] w, input logic [1:0] c,
      input logic oc, input logic m, input logic dn, input logic bt, input logic fc);
    logic n;
    n = oc;
    if (w[1] == 1'b0) begin            // normal / CTC: R6, R9
      if (m || fc) begin
        if (c == 2'b01) n = ~oc;
        else if (c == 2'b10) n = 1'b0;
        else if (c == 2'b11) n = 1'b1;
      end
    end else if (w == 2'b10) begin     // fast PWM: R7
      if (c == 2'b10) begin
        if (bt) n = 1'b1; else if (m) n = 1'b0;
      end else if (c == 2'b11) begin
        if (bt) n = 1'b0; else if (m) n = 1'b1;
      end
    end else begin                     // phase-correct PWM: R8
      if (m && c == 2'b10) n = dn ? 1'b1 : 1'b0;
      else if (m && c == 2'b11) n = dn ? 1'b0 : 1'b1;
    end
    return n;
  endfunction

  task automatic tick(input logic m, input logic dn, input logic bt,
                      input logic fc, input string tag);
    exp_t e;
    @(negedge clk);
    rst = b_rst; wave_mode_i = b_wave; cmp_mode_i = b_com;
    match_i = m; count_down_i = dn; bottom_i = bt; force_i = fc;
    port_data_i = b_pd; port_dir_i = b_dir;
    if (b_rst) begin
      m_oc = 1'b0; m_wave = 2'b00; m_com = 2'b00;
      e.pin = 1'b0; e.oe = 1'b0;
    end else begin
      m_oc  = model_next(m_wave, m_com, m_oc, m, dn, bt, fc);
      e.pin = (m_com != 2'b00) ? m_oc : b_pd;
      e.oe  = b_dir;
      m_wave = b_wave; m_com = b_com;
    end
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_cmp++;
        if (pin_out_o !== e.pin || pin_oe_o !== e.oe) begin
          n_bad++;
          $display("FAIL %s: pin/oe actual %b/%b expected %b/%b",
                   e.tag, pin_out_o, pin_oe_o, e.pin, e.oe);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wave_mode_i = 2'b00; cmp_mode_i = 2'b00;
    match_i = 0; count_down_i = 0; bottom_i = 0; force_i = 0;
    port_data_i = 0; port_dir_i = 0;

    // R1 reset state
    b_rst = 1; b_pd = 1; b_dir = 1;
    tick(0, 0, 0, 0, "R1 reset outputs low");
    tick(0, 0, 0, 0, "R1 reset outputs low");
    b_rst = 0;

    // R2 port pass-through, match ignored
    b_pd = 1; tick(1, 0, 0, 0, "R2 port data 1");
    b_pd = 0; tick(1, 0, 0, 1, "R2 port data 0");
    b_pd = 1; tick(0, 0, 0, 0, "R2 port data 1 again");

    // R3 enable follows direction
    b_dir = 0; tick(0, 0, 0, 0, "R3 dir low");
    b_dir = 1; tick(0, 0, 0, 0, "R3 dir high");

    // R6 normal: toggle, R5 one-cycle latency
    b_pd = 0; b_com = 2'b01;
    tick(1, 0, 0, 0, "R5 field not yet active");
    tick(1, 0, 0, 0, "R6 toggle to 1");
    tick(1, 0, 0, 0, "R6 toggle to 0");
    tick(0, 0, 0, 0, "R6 idle hold");
    b_com = 2'b11; tick(0, 0, 0, 0, "R5 load set field");
    tick(1, 0, 0, 0, "R6 set on match");
    b_com = 2'b10; tick(0, 0, 0, 0, "R4 holds 1 over port 0");
    tick(1, 0, 0, 0, "R6 clear on match");
    // CTC
    b_wave = 2'b01; b_com = 2'b01; tick(0, 0, 0, 0, "R5 load CTC");
    tick(1, 0, 0, 0, "R6 CTC toggle");

    // R9 force
    tick(0, 0, 0, 1, "R9 force toggles");
    tick(1, 0, 0, 1, "R9 force+match toggles once");
    b_com = 2'b11; tick(0, 0, 0, 0, "R9 load set");
    tick(0, 0, 0, 1, "R9 force sets");

    // R11 preset with pin disabled
    b_dir = 0; b_com = 2'b10; b_wave = 2'b00;
    tick(0, 0, 0, 0, "R11 disable pin");
    tick(0, 0, 0, 1, "R11 preset clear while oe low");
    b_com = 2'b11; tick(0, 0, 0, 0, "R11 load set");
    tick(0, 0, 0, 1, "R11 preset set while oe low");
    b_dir = 1; tick(0, 0, 0, 0, "R11 preset visible after enable");

    // R7 fast PWM
    b_wave = 2'b10; b_com = 2'b10; tick(0, 0, 0, 0, "R7 load fast");
    tick(1, 0, 0, 0, "R7 match clears");
    tick(0, 0, 1, 0, "R7 bottom sets");
    tick(1, 0, 0, 0, "R7 match clears again");
    tick(1, 0, 1, 0, "R7 bottom wins over match");
    tick(0, 0, 0, 1, "R10 force ignored fast");
    b_com = 2'b11; tick(0, 0, 0, 0, "R7 load inverting");
    tick(0, 0, 1, 0, "R7 inverting bottom clears");
    tick(1, 0, 0, 0, "R7 inverting match sets");
    b_com = 2'b01; tick(0, 0, 0, 0, "R7 load reserved");
    tick(0, 0, 1, 0, "R7 reserved bottom no change");
    tick(1, 0, 0, 1, "R7 reserved match no change");

    // R8 phase-correct PWM
    b_wave = 2'b11; b_com = 2'b10; tick(0, 0, 0, 0, "R8 load phase");
    tick(1, 0, 0, 0, "R8 up match clears");
    tick(1, 1, 0, 0, "R8 down match sets");
    tick(0, 1, 0, 1, "R10 force ignored phase");
    b_com = 2'b11; tick(0, 0, 0, 0, "R8 load inverting");
    tick(1, 1, 0, 0, "R8 inverting down clears");
    tick(1, 0, 0, 0, "R8 inverting up sets");
    b_com = 2'b01; tick(0, 0, 0, 0, "R8 load reserved");
    tick(1, 1, 0, 0, "R8 reserved no change");

    // R4 override independent of waveform mode, R2 hold with field off
    b_pd = 0; b_com = 2'b00; tick(0, 0, 0, 0, "R4 field off loads");
    tick(1, 1, 0, 0, "R2 port restored");
    b_wave = 2'b00; b_com = 2'b10; tick(1, 0, 0, 0, "R2 match before field active");
    tick(0, 0, 0, 0, "R4 normal shows held 1");

    // R1 reset mid-run
    b_rst = 1; b_com = 2'b11; b_pd = 1;
    tick(0, 0, 0, 0, "R1 reset mid-run");
    b_rst = 0; b_com = 2'b00; b_pd = 1;
    tick(1, 0, 0, 0, "R1 port control after reset");
    b_com = 2'b01; tick(0, 0, 0, 0, "R1 load toggle after reset");
    tick(1, 0, 0, 0, "R1 flop cleared by reset then toggled");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule